// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block sits beside the byte shifter of a serial port used as an I2C master. Software writes an 8-bit control word. Three of its bits ask for a start, a repeated start or a stop condition. The block then plays the matching sequence of open-drain levels on SCL and SDA. Each phase of a sequence lasts a programmable number of system clocks. The block clears the request bit itself once the sequence has completed.

The block also owns the pin multiplexer. When the select bit is 0, the lines come from the byte shifter. In that path SDA can be replaced by a programmed acknowledge level. SCL can be held low after the ninth received clock. SCL can also be released for good once a stop is seen on the bus. When the select bit is 1, the lines carry the levels of the condition generator. Software is expected to arm a request before it sets the select bit; the two may be written in the same word.

All line outputs are open-drain intents: 0 pulls the line low and 1 releases it.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset the control word reads 0x00, `scl_o` and `sda_o` are both 1, and `busy_o` is 0.
- R2: Bits 0 (start), 1 (repeated start) and 2 (stop) take a written 1 only while `i2c_en_i` is 1. While `i2c_en_i` is 0, a written 1 leaves them 0. Bits 7..3 always take the written value.
- R3: A start request drives SDA low with SCL high for one phase, then both low for one phase. Bit 0 reads 0 from the cycle after the last phase, and the generator keeps both lines low.
- R4: A repeated-start request releases SDA with SCL unchanged for one phase, then releases SCL for one phase, then runs the two start phases. Bit 1 clears when the sequence ends.
- R5: A stop request runs four phases in this order: SCL low with SDA unchanged, then SDA low, then SCL released, then SDA released. Bit 2 clears when the sequence ends, and both lines are left released.
- R6: `busy_o` is 1 in exactly the cycles of a running sequence. Writes to bits 2..0 are ignored while `busy_o` is 1. When several requests are armed, start runs first, then repeated start, then stop. Between phases, at most one of the two lines changes per cycle.
- R7: With bit 3 at 0, `scl_o` and `sda_o` follow `sh_scl_i` and `sh_sda_i`. With bit 3 at 1, they carry the generator levels.
- R8: With bit 3 at 0 and bit 4 at 1, `sda_o` equals bit 5 (0 = ACK, line low; 1 = NACK, line released), whatever `sh_sda_i` is.
- R9: With bit 6 at 1, a pulse on `sh_ninth_i` holds `scl_o` low from the next cycle in the shifter path. Writing bit 6 to 0 releases SCL at once. With bit 6 at 0, the pulse has no effect.
- R10: With bit 7 at 1, a pulse on `stop_det_i` forces `scl_o` to 1 in the shifter path until bit 7 is written 0. With bit 7 at 0, SCL keeps following the shifter.
- R11: Every phase lasts `hold_cnt_i` clocks, and a value of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| i2c_en_i | input | 1 | I2C mode enable; gates request bits |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control word write data |
| hold_cnt_i | input | PHASE_W | Phase length in clocks (0 treated as 1) |
| sh_scl_i | input | 1 | SCL level from the byte shifter |
| sh_sda_i | input | 1 | SDA level from the byte shifter |
| sh_ninth_i | input | 1 | Pulse after the ninth received SCL clock |
| stop_det_i | input | 1 | Pulse when a stop condition is detected on the bus |
| ctrl_o | output | 8 | Current control word |
| busy_o | output | 1 | A condition sequence is running |
| scl_o | output | 1 | SCL drive (0 pull low, 1 release) |
| sda_o | output | 1 | SDA drive (0 pull low, 1 release) |

## Verification
A wrong phase state or a miscounted phase shows up on `scl_o`/`sda_o` in the very cycle it takes effect. The bench therefore compares both lines against a cycle-exact expected trace for every phase length it sweeps. A request bit that is never cleared, or cleared too early, shows as a wrong `ctrl_o` bit one cycle after the last phase; a stuck request re-runs the sequence and raises `busy_o` again. A wrong hold or halt flag shows on `scl_o` one cycle after the `sh_ninth_i` or `stop_det_i` pulse, or right after the enabling bit is cleared.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int unsigned CTRL_W = 8;
  localparam int unsigned REQ_W  = 3;

  // control word bit positions
  localparam int unsigned B_START   = 0;
  localparam int unsigned B_RESTART = 1;
  localparam int unsigned B_STOP    = 2;
  localparam int unsigned B_SEL     = 3;
  localparam int unsigned B_ACKSEL  = 4;
  localparam int unsigned B_ACKLVL  = 5;
  localparam int unsigned B_WAIT9   = 6;
  localparam int unsigned B_HALT    = 7;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ST_A,   // SDA low, SCL high
    PH_ST_B,   // both low
    PH_RS_A,   // SDA released, SCL held
    PH_RS_B,   // both released
    PH_SP_A,   // SCL low, SDA held
    PH_SP_B,   // both low
    PH_SP_C,   // SCL released
    PH_SP_D    // SDA released
  } phase_e;

  typedef enum logic [1:0] {
    K_START,
    K_RESTART,
    K_STOP
  } kind_e;

  typedef struct packed {
    logic scl;
    logic sda;
  } lines_t;
endpackage

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              i2c_en_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic [REQ_W-1:0]  done_i,
  input  logic              ninth_i,
  input  logic              stop_det_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              hold_o,
  output logic              halt_o
);
  logic [REQ_W-1:0]        req_q;
  logic [CTRL_W-1:REQ_W]   cfg_q;
  logic                    wait_q;
  logic                    halt_q;

  for (genvar b = 0; b < REQ_W; b++) begin : g_req
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[b] <= 1'b0;
      end else if (we_i && !busy_i) begin
        req_q[b] <= wdata_i[b] & i2c_en_i;
      end else if (done_i[b]) begin
        req_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q <= wdata_i[CTRL_W-1:REQ_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (!cfg_q[B_WAIT9])    wait_q <= 1'b0;
      else if (ninth_i)       wait_q <= 1'b1;
      if (!cfg_q[B_HALT])     halt_q <= 1'b0;
      else if (stop_det_i)    halt_q <= 1'b1;
    end
  end

  assign ctrl_o = {cfg_q, req_q};
  // flag takes effect only while its enable bit is set: clearing releases at once
  assign hold_o = wait_q & cfg_q[B_WAIT9];
  assign halt_o = halt_q & cfg_q[B_HALT];
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REQ_W-1:0]   req_i,
  input  logic [PHASE_W-1:0] len_i,
  output logic               busy_o,
  output logic [REQ_W-1:0]   done_o,
  output lines_t             lines_o
);
  phase_e             ph_q, ph_d;
  kind_e              kind_q, kind_d;
  logic [PHASE_W-1:0] cnt_q, cnt_d;
  lines_t             lv_q, lv_d;
  logic               last;

  assign last = (cnt_q == '0);

  function automatic lines_t phase_level(phase_e p, lines_t cur);
    lines_t l;
    l = cur;
    case (p)
      PH_ST_A: l = '{scl: 1'b1,    sda: 1'b0};
      PH_ST_B: l = '{scl: 1'b0,    sda: 1'b0};
      PH_RS_A: l = '{scl: cur.scl, sda: 1'b1};
      PH_RS_B: l = '{scl: 1'b1,    sda: 1'b1};
      PH_SP_A: l = '{scl: 1'b0,    sda: cur.sda};
      PH_SP_B: l = '{scl: 1'b0,    sda: 1'b0};
      PH_SP_C: l = '{scl: 1'b1,    sda: 1'b0};
      PH_SP_D: l = '{scl: 1'b1,    sda: 1'b1};
      default: l = cur;
    endcase
    return l;
  endfunction

  always_comb begin
    ph_d   = ph_q;
    kind_d = kind_q;
    done_o = '0;
    if (ph_q == PH_IDLE) begin
      if (req_i[B_START]) begin
        ph_d = PH_ST_A; kind_d = K_START;
      end else if (req_i[B_RESTART]) begin
        ph_d = PH_RS_A; kind_d = K_RESTART;
      end else if (req_i[B_STOP]) begin
        ph_d = PH_SP_A; kind_d = K_STOP;
      end
    end else if (last) begin
      case (ph_q)
        PH_ST_A: ph_d = PH_ST_B;
        PH_ST_B: begin
          ph_d = PH_IDLE;
          if (kind_q == K_RESTART) done_o[B_RESTART] = 1'b1;
          else                     done_o[B_START]   = 1'b1;
        end
        PH_RS_A: ph_d = PH_RS_B;
        PH_RS_B: ph_d = PH_ST_A;
        PH_SP_A: ph_d = PH_SP_B;
        PH_SP_B: ph_d = PH_SP_C;
        PH_SP_C: ph_d = PH_SP_D;
        PH_SP_D: begin
          ph_d = PH_IDLE;
          done_o[B_STOP] = 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    lv_d  = lv_q;
    if (ph_d != ph_q) begin
      cnt_d = (len_i == '0) ? '0 : len_i - 1'b1;
      lv_d  = phase_level(ph_d, lv_q);
    end else if (!last) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      kind_q <= K_START;
      cnt_q  <= '0;
      lv_q   <= '{scl: 1'b1, sda: 1'b1};
    end else begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      lv_q   <= lv_d;
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign lines_o = lv_q;
endmodule

// File: rtl/i2c_cond_outmux.sv
module i2c_cond_outmux
  import i2c_cond_pkg::*;
(
  input  logic   sel_i,
  input  logic   ack_sel_i,
  input  logic   ack_lvl_i,
  input  logic   hold_i,
  input  logic   halt_i,
  input  logic   sh_scl_i,
  input  logic   sh_sda_i,
  input  lines_t gen_i,
  output logic   scl_o,
  output logic   sda_o
);
  logic sh_scl, sh_sda;

  always_comb begin
    // halt releases SCL and outranks the ninth-bit hold
    if (halt_i)      sh_scl = 1'b1;
    else if (hold_i) sh_scl = 1'b0;
    else             sh_scl = sh_scl_i;
    sh_sda = ack_sel_i ? ack_lvl_i : sh_sda_i;
  end

  assign scl_o = sel_i ? gen_i.scl : sh_scl;
  assign sda_o = sel_i ? gen_i.sda : sh_sda;
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               i2c_en_i,
  input  logic               ctrl_we_i,
  input  logic [7:0]         ctrl_wdata_i,
  input  logic [PHASE_W-1:0] hold_cnt_i,
  input  logic               sh_scl_i,
  input  logic               sh_sda_i,
  input  logic               sh_ninth_i,
  input  logic               stop_det_i,
  output logic [7:0]         ctrl_o,
  output logic               busy_o,
  output logic               scl_o,
  output logic               sda_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [REQ_W-1:0]  done;
  logic              busy, hold, halt;
  lines_t            gen;

  i2c_cond_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .i2c_en_i   (i2c_en_i),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .busy_i     (busy),
    .done_i     (done),
    .ninth_i    (sh_ninth_i),
    .stop_det_i (stop_det_i),
    .ctrl_o     (ctrl),
    .hold_o     (hold),
    .halt_o     (halt)
  );

  i2c_cond_seq #(.PHASE_W(PHASE_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (ctrl[REQ_W-1:0]),
    .len_i   (hold_cnt_i),
    .busy_o  (busy),
    .done_o  (done),
    .lines_o (gen)
  );

  i2c_cond_outmux u_mux (
    .sel_i     (ctrl[B_SEL]),
    .ack_sel_i (ctrl[B_ACKSEL]),
    .ack_lvl_i (ctrl[B_ACKLVL]),
    .hold_i    (hold),
    .halt_i    (halt),
    .sh_scl_i  (sh_scl_i),
    .sh_sda_i  (sh_sda_i),
    .gen_i     (gen),
    .scl_o     (scl_o),
    .sda_o     (sda_o)
  );

  assign ctrl_o = ctrl;
  assign busy_o = busy;
endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       i2c_en_i,
  input logic       ctrl_we_i,
  input logic       sh_ninth_i,
  input logic       stop_det_i,
  input logic [7:0] ctrl_o,
  input logic       busy_o,
  input logic       scl_o,
  input logic       sda_o
);
  AST_START_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[0]) |-> $past(i2c_en_i)); // R2
  AST_RESTART_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[1]) |-> $past(i2c_en_i)); // R2
  AST_STOP_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[2]) |-> $past(i2c_en_i)); // R2
  AST_START_CLEARS_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_o[0]) && !$past(ctrl_we_i)) |-> ($past(busy_o) && !busy_o)); // R3
  AST_STOP_LEAVES_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_o[2]) && $past(busy_o) && ctrl_o[3] && $past(ctrl_o[3])) |-> (scl_o && sda_o)); // R5
  AST_ONE_LINE_PER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[3] && $past(ctrl_o[3])) |-> ($stable(scl_o) || $stable(sda_o))); // R6
  AST_NO_REQ_WRITE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl_we_i && !ctrl_o[2]) |=> !ctrl_o[2]); // R6
  AST_ACK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[3] && ctrl_o[4] && !$isunknown(ctrl_o)) |-> (sda_o == ctrl_o[5])); // R8
  AST_NINTH_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[6] && !ctrl_o[7] && sh_ninth_i && !ctrl_we_i) |=> (!scl_o || ctrl_o[3])); // R9
  AST_HALT_RELEASES_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7] && stop_det_i && !ctrl_we_i) |=> (scl_o || ctrl_o[3])); // R10
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .i2c_en_i   (i2c_en_i),
  .ctrl_we_i  (ctrl_we_i),
  .sh_ninth_i (sh_ninth_i),
  .stop_det_i (stop_det_i),
  .ctrl_o     (ctrl_o),
  .busy_o     (busy_o),
  .scl_o      (scl_o),
  .sda_o      (sda_o)
);

// File: tb/i2c_cond_gen_test.sv
`timescale 1ns/1ps
module i2c_cond_gen_test;
  localparam int unsigned PHASE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, we = 1'b0;
  logic [7:0] wd = '0;
  logic [PHASE_W-1:0] hold = 8'd1;
  logic sh_scl = 1'b1, sh_sda = 1'b1, ninth = 1'b0, sdet = 1'b0;
  logic [7:0] ctrl;
  logic busy, scl, sda;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic cur_scl = 1'b1, cur_sda = 1'b1;

  always #5 clk = ~clk;

  i2c_cond_gen #(.PHASE_W(PHASE_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .i2c_en_i(en), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .hold_cnt_i(hold), .sh_scl_i(sh_scl), .sh_sda_i(sh_sda), .sh_ninth_i(ninth),
    .stop_det_i(sdet), .ctrl_o(ctrl), .busy_o(busy), .scl_o(scl), .sda_o(sda)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // kind 0 start, 1 restart, 2 stop; the request has just been written
  task automatic run_seq(input int kind, input string req);
    int n;
    int np;
    logic [1:0] ph [4];
    n = (hold == 0) ? 1 : int'(hold);
    case (kind)
      0: begin ph[0] = 2'b10; ph[1] = 2'b00; np = 2; end
      1: begin ph[0] = {cur_scl, 1'b1}; ph[1] = 2'b11; ph[2] = 2'b10; ph[3] = 2'b00; np = 4; end
      default: begin ph[0] = {1'b0, cur_sda}; ph[1] = 2'b00; ph[2] = 2'b10; ph[3] = 2'b11; np = 4; end
    endcase
    chk({req, " armed"}, {7'd0, ctrl[kind]}, 8'd1);
    for (int p = 0; p < np; p++) begin
      for (int c = 0; c < n; c++) begin
        tick();
        chk({req, " lines R11"}, {6'd0, scl, sda}, {6'd0, ph[p]});
        chk({req, " busy R6"}, {7'd0, busy}, 8'd1);
      end
    end
    tick();
    chk({req, " busy end R6"}, {7'd0, busy}, 8'd0);
    chk({req, " self clear"}, {7'd0, ctrl[kind]}, 8'd0);
    chk({req, " lines held"}, {6'd0, scl, sda}, {6'd0, ph[np-1]});
    cur_scl = ph[np-1][1];
    cur_sda = ph[np-1][0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ctrl", ctrl, 8'h00);
    chk("R1 lines", {6'd0, scl, sda}, 8'h03);
    chk("R1 busy", {7'd0, busy}, 8'h00);

    // R2 requests blocked with mode off
    wr(8'h0F);
    chk("R2 gated write", ctrl, 8'h08);
    tick();
    chk("R2 no sequence", {7'd0, busy}, 8'h00);
    chk("R2 lines idle", {6'd0, scl, sda}, 8'h03);
    en = 1'b1;
    wr(8'h00);

    // R3 R4 R5 R11 sweep of phase lengths
    for (int h = 0; h < 6; h++) begin
      hold = (h == 4) ? 8'd0 : ((h == 5) ? 8'd5 : h[7:0] + 8'd1);
      wr(8'h09); run_seq(0, "R3 start");
      wr(8'h0A); run_seq(1, "R4 restart");
      wr(8'h0C); run_seq(2, "R5 stop");
      wr(8'h0C); run_seq(2, "R5 stop from idle");
      wr(8'h0A); run_seq(1, "R4 restart from idle");
      wr(8'h0C); run_seq(2, "R5 stop");
    end

    // R6 priority start before stop, stop follows without a new write
    hold = 8'd2;
    wr(8'h0D);
    chk("R6 both armed", ctrl, 8'h0D);
    run_seq(0, "R6 start first");
    chk("R6 stop pending", {7'd0, ctrl[2]}, 8'd1);
    run_seq(2, "R6 stop second");
    // R6 priority start before restart before stop
    wr(8'h0F);
    run_seq(0, "R6 start of three");
    run_seq(1, "R6 restart of three");
    run_seq(2, "R6 stop of three");

    // R6 request writes ignored while busy
    hold = 8'd4;
    wr(8'h09);
    tick();
    tick();
    chk("R6 busy", {7'd0, busy}, 8'd1);
    wr(8'h1E);
    chk("R6 write ignored busy", ctrl, 8'h19);
    for (int i = 0; i < 20 && busy; i++) tick();
    tick();
    chk("R6 ends", ctrl, 8'h18);
    cur_scl = 1'b0; cur_sda = 1'b0;
    wr(8'h0C); run_seq(2, "R5 stop after ignored");

    // R7 shifter path follows inputs, R8 ack override
    wr(8'h00);
    for (int v = 0; v < 4; v++) begin
      sh_scl = v[1]; sh_sda = v[0];
      tick();
      chk("R7 shifter pass", {6'd0, scl, sda}, {6'd0, v[1:0]});
    end
    for (int a = 0; a < 2; a++) begin
      wr(a[0] ? 8'h30 : 8'h10);
      for (int v = 0; v < 2; v++) begin
        sh_sda = v[0];
        tick();
        chk("R8 ack level", {7'd0, sda}, {7'd0, a[0]});
      end
    end
    sh_scl = 1'b1; sh_sda = 1'b0;
    wr(8'h08);
    chk("R7 generator selected", {6'd0, scl, sda}, 8'h03);

    // R9 ninth-bit hold
    wr(8'h00);
    ninth = 1'b1; tick(); ninth = 1'b0; tick();
    chk("R9 no hold when off", {7'd0, scl}, 8'd1);
    wr(8'h40);
    chk("R9 before pulse", {7'd0, scl}, 8'd1);
    ninth = 1'b1; tick(); ninth = 1'b0;
    chk("R9 held low", {7'd0, scl}, 8'd0);
    tick(); tick();
    chk("R9 still held", {7'd0, scl}, 8'd0);
    wr(8'h00);
    chk("R9 released", {7'd0, scl}, 8'd1);

    // R10 halt on stop detect
    sh_scl = 1'b0;
    wr(8'h00);
    sdet = 1'b1; tick(); sdet = 1'b0; tick();
    chk("R10 continues when off", {7'd0, scl}, 8'd0);
    wr(8'h80);
    chk("R10 before detect", {7'd0, scl}, 8'd0);
    sdet = 1'b1; tick(); sdet = 1'b0;
    chk("R10 halted", {7'd0, scl}, 8'd1);
    wr(8'hC0);
    ninth = 1'b1; tick(); ninth = 1'b0;
    chk("R10 halt over hold", {7'd0, scl}, 8'd1);
    wr(8'h00);
    chk("R10 resumes", {7'd0, scl}, 8'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule